// File: doc/BRIEF.md
# Access Attribute Region Matcher

This block gives every memory reference an effective attribute set. The set has three parts: cacheable or not, precise or imprecise handling of operand writes, and write-protect. References from the processor core and from the debug requester use the same lookup port. The block compares the top byte of the request address against two programmable regions. Each region has a base, a mask, an enable and its own attribute set. The first region that matches supplies the attributes. When neither region matches, a programmable default set is used.

The lookup is combinational from the request inputs to the outputs. The configuration registers are written through a simple synchronous write port. A write reference that resolves to write-protected attributes raises a protection-error output, and the reference is not forwarded. A source code tells which of the three places supplied the attributes.

Top module: `attr_region_matcher`

## Requirements
- R1: While `rst_n` is low at a clock edge, both region enables are cleared and the default attributes become noncacheable, precise and not write-protected (all attribute bits 0). After reset, every reference therefore returns attributes 000 with source code 0.
- R2: An enabled region matches when `req_addr_hi` equals that region's base in every bit where the region's mask is 0. A match drives that region's attributes onto `attr_cacheable`, `attr_imprecise` and `attr_wprot`.
- R3: A mask bit of 1 removes the matching address bit from the compare. A mask of all ones matches every address.
- R4: When both regions match, region 0 supplies the attributes.
- R5: Region 1 supplies the attributes only when region 0 does not match and region 1 does.
- R6: A region whose enable bit is 0 never matches, whatever its base and mask.
- R7: When no region matches, the attributes come from the default register.
- R8: `attr_src` reports 0 for the default, 1 for region 0 and 2 for region 1. The value 3 never appears.
- R9: A valid write reference whose resulting attributes have write-protect set drives `prot_err` high and `req_fwd` low. Any other valid reference drives `req_fwd` high and `prot_err` low. With `req_valid` low, both outputs are low.
- R10: A configuration write with `cfg_we` high stores `cfg_wdata` at the next rising clock edge. `cfg_sel` 0 selects region 0, 1 selects region 1 and 2 selects the default. The data layout is: base [7:0], mask [15:8], enable [16], cacheable [17], imprecise [18], write-protect [19]. The default register uses only bits [19:17].
- R11: A configuration write with `cfg_sel` equal to 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 region 0, 1 region 1, 2 default, 3 none |
| cfg_wdata | input | 20 | Configuration write data |
| req_valid | input | 1 | Reference present |
| req_write | input | 1 | Reference is an operand write |
| req_addr_hi | input | 8 | Address bits [31:24] of the reference |
| attr_cacheable | output | 1 | Effective cacheable attribute |
| attr_imprecise | output | 1 | Effective imprecise-write attribute |
| attr_wprot | output | 1 | Effective write-protect attribute |
| attr_src | output | 2 | Source of the attributes: 0 default, 1 region 0, 2 region 1 |
| req_fwd | output | 1 | Reference may proceed |
| prot_err | output | 1 | Write to a protected region was blocked |

## Verification
The assertions are sampled at the rising clock edge. They take for granted that the request and configuration inputs are stable around that edge, and that no request arrives carrying X. The bench changes every input only at the falling edge and drives only known values. Random request addresses are steered toward the programmed bases in half of the cases, so that hits, overlaps and misses all occur with the generated masks. Random configuration writes cover all four select codes, so that both disabled regions and the unused select code are exercised.

// File: rtl/arm_pkg.sv
// Package: shared types for the attribute region matcher.
// Assumes exactly two regions plus a default, as the fixed priority requires.
package arm_pkg;
    localparam int CMP_W = 8;
    localparam int CFG_W = 2 * CMP_W + 4;

    typedef struct packed {
        logic wprot;
        logic imprecise;
        logic cacheable;
    } attr_t;

    localparam logic [1:0] SRC_DFLT = 2'd0;
    localparam logic [1:0] SRC_R0   = 2'd1;
    localparam logic [1:0] SRC_R1   = 2'd2;
endpackage

// File: rtl/arm_region_reg.sv
// Module: arm_region_reg
// Holds the configuration of one region: base, mask, enable and attributes.
// Assumes the write strobe is already qualified by the register select.
module arm_region_reg
    import arm_pkg::*;
#(
    parameter int W = CMP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2*W+3:0]   wdata,
    output logic [W-1:0]     base,
    output logic [W-1:0]     mask,
    output logic             en,
    output attr_t            attr
);
    localparam int EN_BIT = 2 * W;

    // Store a new configuration on a write; reset clears enable and attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            mask <= '0;
            en   <= 1'b0;
            attr <= '0;
        end else if (wr_en) begin
            base <= wdata[W-1:0];
            mask <= wdata[2*W-1:W];
            en   <= wdata[EN_BIT];
            attr <= attr_t'(wdata[EN_BIT+3:EN_BIT+1]);
        end
    end
endmodule

// File: rtl/arm_region_cmp.sv
// Module: arm_region_cmp
// Masked compare of the address bits against one region's base.
// Assumes mask bits set to 1 are "don't care".
module arm_region_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] base,
    input  logic [W-1:0] mask,
    input  logic         en,
    output logic         hit
);
    // A hit needs the region enabled and no difference in the unmasked bits.
    always_comb begin
        hit = en && (((addr ^ base) & ~mask) == '0);
    end
endmodule

// File: rtl/arm_attr_select.sv
// Module: arm_attr_select
// Fixed-priority choice: region 0, then region 1, then the default.
// Assumes the hit inputs come from independent compares.
module arm_attr_select
    import arm_pkg::*;
(
    input  logic [1:0] hit,
    input  attr_t      attr0,
    input  attr_t      attr1,
    input  attr_t      dflt,
    output attr_t      attr,
    output logic [1:0] src
);
    // Pick the winning attribute set and report where it came from.
    always_comb begin
        if (hit[0]) begin
            attr = attr0;
            src  = SRC_R0;
        end else if (hit[1]) begin
            attr = attr1;
            src  = SRC_R1;
        end else begin
            attr = dflt;
            src  = SRC_DFLT;
        end
    end
endmodule

// File: rtl/attr_region_matcher.sv
// Module: attr_region_matcher
// Gives each memory reference its effective attributes from two masked
// regions and a default, and blocks writes that resolve to write-protected.
// Assumes inputs change away from the rising clock edge.
module attr_region_matcher
    import arm_pkg::*;
#(
    parameter int W    = CMP_W,
    parameter int NREG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [2*W+3:0]   cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [W-1:0]     req_addr_hi,
    output logic             attr_cacheable,
    output logic             attr_imprecise,
    output logic             attr_wprot,
    output logic [1:0]       attr_src,
    output logic             req_fwd,
    output logic             prot_err
);
    localparam int ATTR_LSB = 2 * W + 1;
    localparam logic [1:0] SEL_DFLT = 2'd2;

    logic [W-1:0]    r_base [NREG];
    logic [W-1:0]    r_mask [NREG];
    logic [NREG-1:0] r_en;
    attr_t           r_attr [NREG];
    logic [NREG-1:0] r_hit;
    attr_t           dflt_q;
    attr_t           eff;

    // One register and one comparator per region.
    for (genvar g = 0; g < NREG; g++) begin : g_region
        arm_region_reg #(.W(W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (cfg_we && (cfg_sel == 2'(g))),
            .wdata (cfg_wdata),
            .base  (r_base[g]),
            .mask  (r_mask[g]),
            .en    (r_en[g]),
            .attr  (r_attr[g])
        );
        arm_region_cmp #(.W(W)) u_cmp (
            .addr (req_addr_hi),
            .base (r_base[g]),
            .mask (r_mask[g]),
            .en   (r_en[g]),
            .hit  (r_hit[g])
        );
    end

    // Default attribute register; reset gives noncacheable, precise, unprotected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_q <= '0;
        end else if (cfg_we && cfg_sel == SEL_DFLT) begin
            dflt_q <= attr_t'(cfg_wdata[ATTR_LSB+2:ATTR_LSB]);
        end
    end

    arm_attr_select u_sel (
        .hit   (r_hit),
        .attr0 (r_attr[0]),
        .attr1 (r_attr[1]),
        .dflt  (dflt_q),
        .attr  (eff),
        .src   (attr_src)
    );

    // Drive the attribute outputs and the write-protect gate.
    always_comb begin
        attr_cacheable = eff.cacheable;
        attr_imprecise = eff.imprecise;
        attr_wprot     = eff.wprot;
        prot_err       = req_valid && req_write && eff.wprot;
        req_fwd        = req_valid && !prot_err;
    end

    AST_R0_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        r_hit[0] |-> (attr_src == SRC_R0 && eff == r_attr[0])); // R4
    AST_R1_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_hit[0] && r_hit[1]) |-> (attr_src == SRC_R1 && eff == r_attr[1])); // R5
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !r_en[0] |-> attr_src != SRC_R0); // R6
    AST_DEFAULT_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_hit == '0) |-> (attr_src == SRC_DFLT && eff == dflt_q)); // R7
    AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        attr_src != 2'd3); // R8
    AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> (!req_fwd && attr_wprot && req_write)); // R9
    AST_SEL3_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'd3) |=> ($stable(dflt_q) && $stable(r_en))); // R11
endmodule

// File: tb/attr_region_matcher_tb.sv
module attr_region_matcher_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [19:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr_hi = '0;
    logic        attr_cacheable, attr_imprecise, attr_wprot, req_fwd, prot_err;
    logic [1:0]  attr_src;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] sb [2];
    logic [7:0] sm [2];
    logic       se [2];
    logic [2:0] sa [2];
    logic [2:0] sd;

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_region_matcher u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
        .req_addr_hi(req_addr_hi), .attr_cacheable(attr_cacheable),
        .attr_imprecise(attr_imprecise), .attr_wprot(attr_wprot),
        .attr_src(attr_src), .req_fwd(req_fwd), .prot_err(prot_err)
    );

    // Expected {wprot, imprecise, cacheable, src[1:0], fwd, err} from the requirements.
    function automatic logic [6:0] model(logic [7:0] a, logic v, logic w);
        logic [2:0] at;
        logic [1:0] s;
        logic e;
        if (se[0] && ((a & ~sm[0]) == (sb[0] & ~sm[0]))) begin
            at = sa[0]; s = 2'd1;
        end else if (se[1] && ((a & ~sm[1]) == (sb[1] & ~sm[1]))) begin
            at = sa[1]; s = 2'd2;
        end else begin
            at = sd; s = 2'd0;
        end
        e = v && w && at[2];
        return {at, s, v && !e, e};
    endfunction

    function automatic logic [19:0] pack(logic [7:0] b, logic [7:0] m, logic en, logic [2:0] at);
        return {at, en, m, b};
    endfunction

    task automatic cfg(logic [1:0] sel, logic [19:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel < 2'd2) begin
            sb[sel] = d[7:0]; sm[sel] = d[15:8]; se[sel] = d[16]; sa[sel] = d[19:17];
        end else if (sel == 2'd2) begin
            sd = d[19:17];
        end
    endtask

    task automatic probe(logic [7:0] a, logic v, logic w, string tag);
        logic [6:0] exp, act;
        @(negedge clk);
        req_addr_hi = a; req_valid = v; req_write = w;
        #1;
        exp = model(a, v, w);
        act = {attr_wprot, attr_imprecise, attr_cacheable, attr_src, req_fwd, prot_err};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h act=%b exp=%b", tag, a, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            sb[i] = '0; sm[i] = '0; se[i] = 1'b0; sa[i] = '0;
        end
        sd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        probe(8'h00, 1'b1, 1'b1, "R1 reset");
        probe(8'hFF, 1'b1, 1'b0, "R1 reset");
        // R2 R10: region 0 exact match, cacheable
        cfg(2'd0, pack(8'h20, 8'h00, 1'b1, 3'b001));
        probe(8'h20, 1'b1, 1'b0, "R2 exact hit");
        probe(8'h21, 1'b1, 1'b0, "R2 miss");
        // R3 R5: region 1 masked low nibble, imprecise
        cfg(2'd1, pack(8'h40, 8'h0F, 1'b1, 3'b010));
        probe(8'h4A, 1'b1, 1'b0, "R3 R5 masked hit");
        probe(8'h50, 1'b1, 1'b0, "R3 unmasked bit differs");
        // R4: region 0 all-mask overlaps region 1, write-protected
        cfg(2'd0, pack(8'h00, 8'hFF, 1'b1, 3'b100));
        probe(8'h4A, 1'b1, 1'b0, "R4 priority");
        // R9: protected write blocked, read forwarded, invalid quiet
        probe(8'h4A, 1'b1, 1'b1, "R9 protected write");
        probe(8'h4A, 1'b0, 1'b1, "R9 invalid");
        // R6: disabled region 0 with matching base
        cfg(2'd0, pack(8'h4A, 8'hFF, 1'b0, 3'b111));
        probe(8'h4A, 1'b1, 1'b1, "R6 disabled");
        // R7: programmed default
        cfg(2'd2, pack(8'hAA, 8'hAA, 1'b1, 3'b101));
        probe(8'h99, 1'b1, 1'b1, "R7 default");
        probe(8'h99, 1'b1, 1'b0, "R7 default read");
        // R11: select 3 changes nothing
        cfg(2'd3, 20'hFFFFF);
        probe(8'h99, 1'b1, 1'b1, "R11 sel3 default");
        probe(8'h4A, 1'b1, 1'b0, "R11 sel3 region");
        // Random mix, R8 on every probe
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            if ($urandom_range(0, 3) == 0)
                cfg(2'($urandom_range(0, 3)), 20'($urandom));
            a = 8'($urandom);
            if ($urandom_range(0, 1) == 1) begin
                int r = $urandom_range(0, 1);
                a = (sb[r] & ~sm[r]) | (a & sm[r]);
            end
            probe(a, 1'($urandom_range(0, 7) != 0), 1'($urandom), "R2 R4 R8 random");
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule